// File: doc/BRIEF.md
# Exception Entry Controller

This block performs exception entry for a small 32-bit soft processor. The core raises one or more bits of a request vector, one bit per exception code, and presents the program counter of the faulting or interrupted instruction. In the clock cycle of the request the controller does four things. It picks the request with the lowest code and sorts it into the debug class or the ordinary class. It saves the program counter into the return register of that class. It moves the global interrupt enable into the saved-enable bit of that class and then clears the global enable. It computes the handler address from one of two vector bases, using a fixed 32-byte step per code. The handler address and a one-cycle redirect strobe appear on the outputs after the clock edge.

A simple write port lets software load the two base addresses, the enable bits, the remap control bit and both return registers. All of this state is visible on output ports. A request whose selected code is not one of the seven defined types does not redirect. Instead it latches a fatal flag, which stays set until reset and halts all further exception entry.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After synchronous reset, every control register (enable bits, both bases, remap bit, both return registers), `new_pc`, `redirect` and `fatal` read zero.
- R2: Codes 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call) are ordinary exceptions and copy `pc` into `ea`. Codes 1 (breakpoint) and 3 (watchpoint) are debug exceptions and copy `pc` into `ba`. The other return register keeps its value.
- R3: `ie_bits` holds the global enable in bit 0, the ordinary saved enable in bit 1 and the debug saved enable in bit 2. On entry, the saved bit of the class becomes 1 if bit 0 was 1 and otherwise keeps its value. Bit 0 is then cleared.
- R4: The handler address equals the debug base when `remap` is 1, or the normal base when it is 0, plus 32 times the code. This holds for both classes.
- R5: Entry takes one clock edge. In the cycle after a request cycle, `redirect` is 1 and `new_pc` holds the handler address. `redirect` is 0 after any cycle without a served request, and `new_pc` then holds its last value.
- R6: If the selected code is 0 or is 8 or higher, `fatal` is set instead of a redirect, and no other register changes. `fatal` stays set until reset. While it is set, requests change nothing.
- R7: The low 8 bits of both base registers always read zero, and writes to those bits have no effect.
- R8: A write with `wr_en`=1 updates the register chosen by `wr_sel` at the next edge. The selector values are 0 for the enable bits (data bits 2:0), 1 for the normal base, 2 for the debug base, 3 for the remap bit (data bit 0), 4 for `ea` and 5 for `ba`.
- R9: A write is ignored in any cycle in which `exc_req` is nonzero.
- R10: When several request bits are set, only the lowest set bit is served. The others have no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 16 | One request bit per exception code |
| pc | input | 32 | Program counter to save |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 32 | Write data |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| new_pc | output | 32 | Handler address |
| fatal | output | 1 | Sticky unhandled-exception flag |
| ie_bits | output | 3 | Saved debug enable, saved ordinary enable, global enable |
| ea | output | 32 | Ordinary exception return address |
| ba | output | 32 | Debug exception return address |
| eba | output | 32 | Normal vector base |
| deba | output | 32 | Debug vector base |
| remap | output | 1 | Selects the debug base for all vectors |

## Verification
The assertions check on every cycle the properties that hold locally. Both bases stay aligned. Every redirect follows a request cycle, lands on a 32-byte boundary and leaves the global enable cleared. The saved enable bits never drop on entry. Once the fatal flag is set it stays set and suppresses redirects. Other behaviour depends on the data, and only the bench scenarios can show it: which return register captured the program counter, the exact handler address under each base and remap setting, lowest-code selection among simultaneous requests, and writes that are dropped during a request. A reference model in the bench predicts these values every cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    // write-port register selectors
    typedef enum logic [2:0] {
        SEL_IE   = 3'd0,
        SEL_EBA  = 3'd1,
        SEL_DEBA = 3'd2,
        SEL_DC   = 3'd3,
        SEL_EA   = 3'd4,
        SEL_BA   = 3'd5
    } csr_sel_e;

    // class of the selected request
    typedef enum logic [1:0] {
        CLS_NONE   = 2'd0,
        CLS_NORMAL = 2'd1,
        CLS_DEBUG  = 2'd2,
        CLS_FATAL  = 2'd3
    } exc_class_e;

    // enable bits; packed so that ie sits in bit 0
    typedef struct packed {
        logic bie;
        logic eie;
        logic ie;
    } ie_reg_t;

    localparam int unsigned CODE_BREAK    = 1;
    localparam int unsigned CODE_IBUS     = 2;
    localparam int unsigned CODE_WATCH    = 3;
    localparam int unsigned CODE_DBUS     = 4;
    localparam int unsigned CODE_DIVZERO  = 5;
    localparam int unsigned CODE_IRQ      = 6;
    localparam int unsigned CODE_SYSCALL  = 7;

    function automatic exc_class_e classify(input int unsigned code);
        case (code)
            CODE_BREAK, CODE_WATCH:                       return CLS_DEBUG;
            CODE_IBUS, CODE_DBUS, CODE_DIVZERO,
            CODE_IRQ, CODE_SYSCALL:                       return CLS_NORMAL;
            default:                                      return CLS_FATAL;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio_classify.sv
module exc_prio_classify
    import exc_entry_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic [(1<<CODE_W)-1:0] req,
    output logic                   any_req,
    output logic [CODE_W-1:0]      code,
    output exc_class_e             cls
);
    localparam int NSRC = 1 << CODE_W;

    // lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        code = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) code = CODE_W'(i);
        end
    end

    assign any_req = |req;

    always_comb begin
        if (!any_req) cls = CLS_NONE;
        else          cls = classify(32'(code));
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
    parameter int XLEN       = 32,
    parameter int CODE_W     = 4,
    parameter int STRIDE_LOG = 5
) (
    input  logic [XLEN-1:0]   eba,
    input  logic [XLEN-1:0]   deba,
    input  logic              remap,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   vector
);
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    assign base   = remap ? deba : eba;
    assign offset = XLEN'(code) << STRIDE_LOG;
    assign vector = base + offset;

endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int BASE_ALIGN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            any_req,
    input  exc_class_e      cls,
    input  logic [XLEN-1:0] pc,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [XLEN-1:0] wr_data,
    output ie_reg_t         ie_q,
    output logic [XLEN-1:0] ea_q,
    output logic [XLEN-1:0] ba_q,
    output logic [XLEN-1:0] eba_q,
    output logic [XLEN-1:0] deba_q,
    output logic            remap_q,
    output logic            fatal_q
);
    localparam logic [XLEN-1:0] BASE_MASK = {{(XLEN-BASE_ALIGN){1'b1}}, {BASE_ALIGN{1'b0}}};

    csr_sel_e sel;
    assign sel = csr_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q    <= '0;
            ea_q    <= '0;
            ba_q    <= '0;
            eba_q   <= '0;
            deba_q  <= '0;
            remap_q <= 1'b0;
            fatal_q <= 1'b0;
        end else if (any_req) begin
            if (!fatal_q) begin
                case (cls)
                    CLS_NORMAL: begin
                        ea_q    <= pc;
                        ie_q.eie <= ie_q.eie | ie_q.ie;
                        ie_q.ie  <= 1'b0;
                    end
                    CLS_DEBUG: begin
                        ba_q    <= pc;
                        ie_q.bie <= ie_q.bie | ie_q.ie;
                        ie_q.ie  <= 1'b0;
                    end
                    CLS_FATAL: fatal_q <= 1'b1;
                    default: ;
                endcase
            end
        end else if (wr_en) begin
            case (sel)
                SEL_IE:   ie_q    <= ie_reg_t'(wr_data[2:0]);
                SEL_EBA:  eba_q   <= wr_data & BASE_MASK;
                SEL_DEBA: deba_q  <= wr_data & BASE_MASK;
                SEL_DC:   remap_q <= wr_data[0];
                SEL_EA:   ea_q    <= wr_data;
                SEL_BA:   ba_q    <= wr_data;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int CODE_W     = 4,
    parameter int STRIDE_LOG = 5,
    parameter int BASE_ALIGN = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [(1<<CODE_W)-1:0] exc_req,
    input  logic [XLEN-1:0]        pc,
    input  logic                   wr_en,
    input  logic [2:0]             wr_sel,
    input  logic [XLEN-1:0]        wr_data,
    output logic                   redirect,
    output logic [XLEN-1:0]        new_pc,
    output logic                   fatal,
    output logic [2:0]             ie_bits,
    output logic [XLEN-1:0]        ea,
    output logic [XLEN-1:0]        ba,
    output logic [XLEN-1:0]        eba,
    output logic [XLEN-1:0]        deba,
    output logic                   remap
);
    logic              any_req;
    logic [CODE_W-1:0] sel_code;
    exc_class_e        sel_cls;
    logic [XLEN-1:0]   vector;
    ie_reg_t           ie_q;
    logic              serve;
    logic              redirect_q;
    logic [XLEN-1:0]   new_pc_q;

    exc_prio_classify #(.CODE_W(CODE_W)) i_prio (
        .req     (exc_req),
        .any_req (any_req),
        .code    (sel_code),
        .cls     (sel_cls)
    );

    exc_vector_gen #(.XLEN(XLEN), .CODE_W(CODE_W), .STRIDE_LOG(STRIDE_LOG)) i_vec (
        .eba    (eba),
        .deba   (deba),
        .remap  (remap),
        .code   (sel_code),
        .vector (vector)
    );

    exc_csr_file #(.XLEN(XLEN), .BASE_ALIGN(BASE_ALIGN)) i_csr (
        .clk     (clk),
        .rst     (rst),
        .any_req (any_req),
        .cls     (sel_cls),
        .pc      (pc),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ie_q    (ie_q),
        .ea_q    (ea),
        .ba_q    (ba),
        .eba_q   (eba),
        .deba_q  (deba),
        .remap_q (remap),
        .fatal_q (fatal)
    );

    assign serve = any_req && !fatal && (sel_cls == CLS_NORMAL || sel_cls == CLS_DEBUG);

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_q <= 1'b0;
            new_pc_q   <= '0;
        end else begin
            redirect_q <= serve;
            if (serve) new_pc_q <= vector;
        end
    end

    assign redirect = redirect_q;
    assign new_pc   = new_pc_q;
    assign ie_bits  = ie_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int XLEN       = 32,
    parameter int CODE_W     = 4,
    parameter int STRIDE_LOG = 5,
    parameter int BASE_ALIGN = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [(1<<CODE_W)-1:0] exc_req,
    input logic                   redirect,
    input logic [XLEN-1:0]        new_pc,
    input logic                   fatal,
    input logic [2:0]             ie_bits,
    input logic [XLEN-1:0]        eba,
    input logic [XLEN-1:0]        deba
);
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (eba[BASE_ALIGN-1:0] == '0) && (deba[BASE_ALIGN-1:0] == '0)); // R7

    AST_REDIRECT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        redirect |-> ($past(exc_req) != '0)); // R5

    AST_VECTOR_STRIDE: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (new_pc[STRIDE_LOG-1:0] == '0)); // R4

    AST_IE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        redirect |-> !ie_bits[0]); // R3

    AST_SAVED_EIE_KEPT: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (!$past(ie_bits[1]) || ie_bits[1])); // R3

    AST_SAVED_BIE_KEPT: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (!$past(ie_bits[2]) || ie_bits[2])); // R3

    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fatal |=> fatal); // R6

    AST_FATAL_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        fatal |-> !redirect); // R6

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN(XLEN), .CODE_W(CODE_W), .STRIDE_LOG(STRIDE_LOG), .BASE_ALIGN(BASE_ALIGN)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .exc_req  (exc_req),
    .redirect (redirect),
    .new_pc   (new_pc),
    .fatal    (fatal),
    .ie_bits  (ie_bits),
    .eba      (eba),
    .deba     (deba)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] exc_req = '0;
    logic [31:0] pc = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        redirect, fatal, remap;
    logic [31:0] new_pc, ea, ba, eba, deba;
    logic [2:0]  ie_bits;

    int checks = 0;
    int failures = 0;

    // bench model state
    logic [2:0]  m_ie;
    logic [31:0] m_ea, m_ba, m_eba, m_deba, m_npc;
    logic        m_re, m_fatal, m_redir;

    always #5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst(rst), .exc_req(exc_req), .pc(pc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .redirect(redirect), .new_pc(new_pc), .fatal(fatal),
        .ie_bits(ie_bits), .ea(ea), .ba(ba), .eba(eba), .deba(deba), .remap(remap)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "redirect", 32'(redirect), 32'(m_redir));
        chk(tag, "new_pc",   new_pc,        m_npc);
        chk(tag, "fatal",    32'(fatal),    32'(m_fatal));
        chk(tag, "ie_bits",  32'(ie_bits),  32'(m_ie));
        chk(tag, "ea",       ea,            m_ea);
        chk(tag, "ba",       ba,            m_ba);
        chk(tag, "eba",      eba,           m_eba);
        chk(tag, "deba",     deba,          m_deba);
        chk(tag, "remap",    32'(remap),    32'(m_re));
    endtask

    function automatic int code_class(input int c);
        // 1 ordinary, 2 debug, 0 unhandled
        if (c == 1 || c == 3) return 2;
        if (c == 2 || c == 4 || c == 5 || c == 6 || c == 7) return 1;
        return 0;
    endfunction

    task automatic model_reset();
        m_ie = '0; m_ea = '0; m_ba = '0; m_eba = '0; m_deba = '0;
        m_npc = '0; m_re = 1'b0; m_fatal = 1'b0; m_redir = 1'b0;
    endtask

    task automatic model_step();
        int lo;
        int cl;
        m_redir = 1'b0;
        if (exc_req != '0) begin
            lo = 0;
            for (int i = 15; i >= 0; i--) if (exc_req[i]) lo = i;
            cl = code_class(lo);
            if (!m_fatal) begin
                if (cl == 0) begin
                    m_fatal = 1'b1;
                end else begin
                    m_npc = (m_re ? m_deba : m_eba) + 32'(lo * 32);
                    m_redir = 1'b1;
                    if (cl == 1) begin m_ea = pc; m_ie[1] = m_ie[1] | m_ie[0]; end
                    else         begin m_ba = pc; m_ie[2] = m_ie[2] | m_ie[0]; end
                    m_ie[0] = 1'b0;
                end
            end
        end else if (wr_en) begin
            case (wr_sel)
                3'd0: m_ie   = wr_data[2:0];
                3'd1: m_eba  = wr_data & 32'hFFFF_FF00;
                3'd2: m_deba = wr_data & 32'hFFFF_FF00;
                3'd3: m_re   = wr_data[0];
                3'd4: m_ea   = wr_data;
                3'd5: m_ba   = wr_data;
                default: ;
            endcase
        end
    endtask

    // one cycle: drive away from the edge, model, clock, sample after the edge
    task automatic cyc(input logic [15:0] r, input logic [31:0] p, input logic we,
                       input logic [2:0] s, input logic [31:0] d, input string tag);
        @(negedge clk);
        exc_req = r; pc = p; wr_en = we; wr_sel = s; wr_data = d;
        model_step();
        @(posedge clk);
        #1;
        compare_all(tag);
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d, input string tag);
        cyc('0, 32'h0, 1'b1, s, d, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; exc_req = '0; wr_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        #1500000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        // R7 R8: base writes drop the low byte
        wr(3'd1, 32'h1234_56FF, "R7 R8 eba write");
        wr(3'd2, 32'hABCD_00FF, "R7 R8 deba write");
        wr(3'd0, 32'h0000_0001, "R8 ie write");

        // R2 R3 R4 R5: ordinary class, normal base
        cyc(16'h0004, 32'h0000_1000, 1'b0, 3'd0, 32'h0, "R2 R3 R4 R5 ibus error entry");
        cyc('0, 32'h0, 1'b0, 3'd0, 32'h0, "R5 strobe drops");

        // debug class with IE set
        wr(3'd0, 32'h0000_0001, "R8 ie write");
        cyc(16'h0002, 32'h0000_2000, 1'b0, 3'd0, 32'h0, "R2 R3 breakpoint entry");

        // remap to debug base for both classes
        wr(3'd3, 32'h0000_0001, "R8 remap write");
        cyc(16'h0008, 32'h0000_3000, 1'b0, 3'd0, 32'h0, "R4 watchpoint with remap");
        cyc(16'h0080, 32'h0000_3004, 1'b0, 3'd0, 32'h0, "R4 syscall with remap");

        // IE clear: saved bits unchanged
        wr(3'd0, 32'h0000_0000, "R8 ie clear");
        cyc(16'h0020, 32'h0000_4000, 1'b0, 3'd0, 32'h0, "R3 divzero with ie clear");

        // R9: write during a request is dropped
        cyc(16'h0040, 32'h0000_5000, 1'b1, 3'd1, 32'hFFFF_FFFF, "R9 write with request");
        cyc('0, 32'h0, 1'b0, 3'd0, 32'h0, "R9 eba unchanged");

        // R10: lowest code among several
        wr(3'd3, 32'h0000_0000, "R8 remap clear");
        wr(3'd0, 32'h0000_0001, "R8 ie write");
        cyc(16'h0048, 32'h0000_6000, 1'b0, 3'd0, 32'h0, "R10 codes 3 and 6");
        cyc(16'h00F0, 32'h0000_7000, 1'b0, 3'd0, 32'h0, "R10 codes 4 to 7");
        wr(3'd4, 32'hDEAD_BEEF, "R8 ea write");
        wr(3'd5, 32'hCAFE_F00D, "R8 ba write");

        // random mix of valid requests and writes
        for (int n = 0; n < 400; n++) begin
            int k;
            logic [15:0] r;
            k = int'($urandom_range(0, 9));
            r = '0;
            if (k < 4) r = 16'($urandom) & 16'h00FE;
            cyc(r, $urandom, 1'($urandom), 3'($urandom_range(0, 5)), $urandom,
                "R2 R3 R4 R8 R9 R10 random");
        end

        // R6: code 0 is unhandled; sticky and blocks later entries
        wr(3'd0, 32'h0000_0001, "R8 ie write");
        cyc(16'h0001, 32'h0000_8000, 1'b0, 3'd0, 32'h0, "R6 code 0 fatal");
        cyc(16'h0004, 32'h0000_8004, 1'b0, 3'd0, 32'h0, "R6 request after fatal");
        cyc('0, 32'h0, 1'b0, 3'd0, 32'h0, "R6 fatal held");
        do_reset();
        @(posedge clk);
        #1;
        compare_all("R1 reset clears fatal");

        // R6: code above 7
        wr(3'd1, 32'h0001_0000, "R8 eba write");
        cyc(16'h0200, 32'h0000_9000, 1'b0, 3'd0, 32'h0, "R6 code 9 fatal");
        cyc(16'h0C00, 32'h0000_9004, 1'b0, 3'd0, 32'h0, "R6 code 10 ignored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule